// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block holds the 16-bit control register through which software starts, watches and checks flash program and erase jobs. Software writes the register with the start bit, the enable bit and an operation code. If the attempt is legal, the sequencer latches the code and the target address, then sends a one-cycle command pulse to the flash array. It waits for the array's done pulse and clears the start bit when the job ends. A job that was not started properly, was cut short by software, or never finished raises a sticky error bit instead.

The block also has two low-power duties. A power-save request is refused while a job is in flight. When the standby option is set, leaving idle holds the flash unavailable for a fixed regulator settling time. Start, enable, error and the operation code survive a system reset and are cleared only by power-on reset.

Top module: `flash_ctl_unit`

## Requirements
- R1: After power-on reset the register reads 0x0000. Bits 11 to 4 always read 0, and whatever is written to them is dropped.
- R2: Software cannot clear the start bit (bit 15) by finishing a job. The sequencer clears it when the array reports done, and the error bit (bit 13) then reads 0.
- R3: A start attempt (bit 15 written as 1 while not busy) whose written enable bit (bit 14) is 0 issues no command and sets the error bit.
- R4: A legal start issues exactly one `cmdStart` pulse, one cycle after the write. The pulse carries `cmdAddr` equal to `addrIn` at the write. `cmdOp` is 0 for code 0000 (configuration byte), 1 for 0001 (word pair), 2 for 0010 (row), 3 for 0011 (page erase), 4 for 1010 (auxiliary bulk erase) and 5 for 1101 (primary bulk erase).
- R5: A start attempt with any other code in bits 3 to 0 issues no command and sets the error bit.
- R6: A word-pair job issues two commands: the first at the latched address and the second at that address plus one. The job completes only after the second done.
- R7: While busy, a write that keeps bit 15 at 1 leaves the enable, error and code fields unchanged.
- R8: While busy, a write with bit 15 at 0 aborts the job. The start bit clears and the error bit is set.
- R9: If no done arrives within TIMEOUT_CYC cycles of a command, the job ends with the start bit cleared and the error bit set.
- R10: `pwrSaveGrant` follows `pwrSaveReq` while no job is busy and is 0 while one is.
- R11: A system reset (`sysRstN` low) clears only the standby bit (bit 12) and the wake timer. Bits 15, 14, 13 and 3 to 0 keep their values.
- R12: With the standby bit at 1, a falling `idleIn` holds `flashReady` at 0 for WAKE_CYC cycles. A start attempt in that window is rejected with the error bit set. With the standby bit at 0, `flashReady` stays 1.
- R13: While not busy, any write loads bits 14, 13, 12 and 3 to 0 from the written data. The error bit is the one exception: it is forced to 1 when the write is a rejected start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, clears everything |
| sysRstN | input | 1 | System reset, active low, clears standby bit and wake timer only |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read value |
| addrIn | input | ADDR_W | Target address captured on a legal start |
| idleIn | input | 1 | High while the system is in idle |
| pwrSaveReq | input | 1 | Request to enter power save |
| pwrSaveGrant | output | 1 | Power save allowed |
| flashReady | output | 1 | Low during regulator wake-up delay |
| cmdStart | output | 1 | One-cycle command pulse to the flash array |
| cmdOp | output | 3 | Decoded operation kind |
| cmdAddr | output | ADDR_W | Command address |
| cmdDone | input | 1 | Completion pulse from the flash array |

## Verification
The hardest states to reach are the ones that need a write to land while a job is in flight or the wake window is open. These are the R7 and R8 writes during busy, the R12 start attempt inside the settling window, and the R9 timeout. The bench's flash responder answers after a fixed latency that is long enough for these writes to fall inside the busy window. The responder can also be told to never answer. Idle exits are driven at a known negedge, so the wake window's first and last cycles are sampled exactly. Random register writes with random codes, enables and junk in the unused bits then cover the legal/illegal start split and the field loading.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

  localparam int GO_BIT   = 15;
  localparam int EN_BIT   = 14;
  localparam int ERR_BIT  = 13;
  localparam int STBY_BIT = 12;

  typedef enum logic [2:0] {
    OP_CFG_BYTE   = 3'd0,
    OP_WORD_PAIR  = 3'd1,
    OP_ROW        = 3'd2,
    OP_PAGE_ERASE = 3'd3,
    OP_AUX_BULK   = 3'd4,
    OP_MAIN_BULK  = 3'd5
  } flashOp_e;

  typedef struct packed {
    logic launch;
    logic reject;
    logic abort;
    logic finish;
    logic expire;
    logic issue;
    logic nextWord;
  } seqStrobe_t;

  function automatic logic opLegal(input logic [3:0] code);
    case (code)
      4'h0, 4'h1, 4'h2, 4'h3, 4'hA, 4'hD: opLegal = 1'b1;
      default:                            opLegal = 1'b0;
    endcase
  endfunction

  function automatic flashOp_e opKind(input logic [3:0] code);
    case (code)
      4'h1:    opKind = OP_WORD_PAIR;
      4'h2:    opKind = OP_ROW;
      4'h3:    opKind = OP_PAGE_ERASE;
      4'hA:    opKind = OP_AUX_BULK;
      4'hD:    opKind = OP_MAIN_BULK;
      default: opKind = OP_CFG_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/flash_ctl_dp.sv
module flash_ctl_dp
  import flash_ctl_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WAKE_CYC    = 8,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              regWrEn,
  input  logic              wrEnBit,
  input  logic              wrErrBit,
  input  logic              wrStbyBit,
  input  logic [3:0]        wrCode,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              idleIn,
  input  seqStrobe_t        strobe,
  output logic [15:0]       regRdData,
  output logic [3:0]        opSel,
  output logic              goBit,
  output logic              wakeBusy,
  output logic              toHit,
  output logic [ADDR_W-1:0] cmdAddr
);

  localparam int WAKE_W = $clog2(WAKE_CYC + 1);
  localparam int TO_W   = $clog2(TIMEOUT_CYC + 1);

  logic              wrEnable;
  logic              seqErr;
  logic              idleStby;
  logic              idlePrev;
  logic [WAKE_W-1:0] wakeCnt;
  logic [TO_W-1:0]   toCnt;
  logic              plainWrite;

  assign plainWrite = regWrEn && !goBit;

  // Fields kept across system reset: cleared by power-on reset only
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      goBit    <= 1'b0;
      wrEnable <= 1'b0;
      seqErr   <= 1'b0;
      opSel    <= 4'h0;
      cmdAddr  <= '0;
      toCnt    <= '0;
    end else begin
      if (strobe.launch) begin
        goBit <= 1'b1;
      end else if (strobe.finish || strobe.abort || strobe.expire) begin
        goBit <= 1'b0;
      end

      if (plainWrite) begin
        wrEnable <= wrEnBit;
        opSel    <= wrCode;
      end

      if (strobe.reject || strobe.abort || strobe.expire) begin
        seqErr <= 1'b1;
      end else if (strobe.finish) begin
        seqErr <= 1'b0;
      end else if (plainWrite) begin
        seqErr <= wrErrBit;
      end

      if (strobe.launch) begin
        cmdAddr <= addrIn;
      end else if (strobe.nextWord) begin
        cmdAddr <= cmdAddr + ADDR_W'(1);
      end

      if (strobe.issue) begin
        toCnt <= '0;
      end else if (goBit && !toHit) begin
        toCnt <= toCnt + TO_W'(1);
      end
    end
  end

  // Fields cleared by either reset
  always_ff @(posedge clk or negedge porRstN or negedge sysRstN) begin
    if (!porRstN || !sysRstN) begin
      idleStby <= 1'b0;
      idlePrev <= 1'b0;
      wakeCnt  <= '0;
    end else begin
      if (regWrEn) begin
        idleStby <= wrStbyBit;
      end
      idlePrev <= idleIn;
      if (idlePrev && !idleIn && idleStby) begin
        wakeCnt <= WAKE_W'(WAKE_CYC);
      end else if (wakeCnt != '0) begin
        wakeCnt <= wakeCnt - WAKE_W'(1);
      end
    end
  end

  assign wakeBusy  = (wakeCnt != '0);
  assign toHit     = (toCnt == TO_W'(TIMEOUT_CYC - 1));
  assign regRdData = {goBit, wrEnable, seqErr, idleStby, 8'h00, opSel};

endmodule

// File: rtl/flash_ctl_ctrl.sv
module flash_ctl_ctrl
  import flash_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       porRstN,
  input  logic       regWrEn,
  input  logic       wrGo,
  input  logic       wrEnBit,
  input  logic [3:0] wrCode,
  input  logic [3:0] opSel,
  input  logic       wakeBusy,
  input  logic       toHit,
  input  logic       cmdDone,
  output seqStrobe_t strobe,
  output logic       cmdStart,
  output logic [2:0] cmdOp
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seqState_e;

  seqState_e state, stateNext;
  logic      secondHalf, secondNext;
  logic      abortReq;

  assign abortReq = regWrEn && !wrGo;

  always_comb begin
    strobe     = '0;
    stateNext  = state;
    secondNext = secondHalf;
    case (state)
      S_IDLE: begin
        if (regWrEn && wrGo) begin
          if (wrEnBit && opLegal(wrCode) && !wakeBusy) begin
            strobe.launch = 1'b1;
            secondNext    = 1'b0;
            stateNext     = S_ISSUE;
          end else begin
            strobe.reject = 1'b1;
          end
        end
      end
      S_ISSUE: begin
        if (abortReq) begin
          strobe.abort = 1'b1;
          stateNext    = S_IDLE;
        end else begin
          strobe.issue = 1'b1;
          stateNext    = S_WAIT;
        end
      end
      S_WAIT: begin
        if (abortReq) begin
          strobe.abort = 1'b1;
          stateNext    = S_IDLE;
        end else if (cmdDone) begin
          if (opKind(opSel) == OP_WORD_PAIR && !secondHalf) begin
            strobe.nextWord = 1'b1;
            secondNext      = 1'b1;
            stateNext       = S_ISSUE;
          end else begin
            strobe.finish = 1'b1;
            stateNext     = S_IDLE;
          end
        end else if (toHit) begin
          strobe.expire = 1'b1;
          stateNext     = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      state      <= S_IDLE;
      secondHalf <= 1'b0;
    end else begin
      state      <= stateNext;
      secondHalf <= secondNext;
    end
  end

  assign cmdStart = (state == S_ISSUE);
  assign cmdOp    = opKind(opSel);

endmodule

// File: rtl/flash_ctl_unit.sv
module flash_ctl_unit
  import flash_ctl_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WAKE_CYC    = 8,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              idleIn,
  input  logic              pwrSaveReq,
  output logic              pwrSaveGrant,
  output logic              flashReady,
  output logic              cmdStart,
  output logic [2:0]        cmdOp,
  output logic [ADDR_W-1:0] cmdAddr,
  input  logic              cmdDone
);

  seqStrobe_t strobe;
  logic [3:0] opSel;
  logic       goBit;
  logic       wakeBusy;
  logic       toHit;
  logic       unusedWrBits;

  assign unusedWrBits = ^regWrData[11:4];

  flash_ctl_dp #(
    .ADDR_W(ADDR_W), .WAKE_CYC(WAKE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_dp (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
    .regWrEn(regWrEn),
    .wrEnBit(regWrData[EN_BIT]), .wrErrBit(regWrData[ERR_BIT]),
    .wrStbyBit(regWrData[STBY_BIT]), .wrCode(regWrData[3:0]),
    .addrIn(addrIn), .idleIn(idleIn), .strobe(strobe),
    .regRdData(regRdData), .opSel(opSel), .goBit(goBit),
    .wakeBusy(wakeBusy), .toHit(toHit), .cmdAddr(cmdAddr)
  );

  flash_ctl_ctrl u_ctrl (
    .clk(clk), .porRstN(porRstN), .regWrEn(regWrEn),
    .wrGo(regWrData[GO_BIT]), .wrEnBit(regWrData[EN_BIT]),
    .wrCode(regWrData[3:0]), .opSel(opSel), .wakeBusy(wakeBusy),
    .toHit(toHit), .cmdDone(cmdDone), .strobe(strobe),
    .cmdStart(cmdStart), .cmdOp(cmdOp)
  );

  assign pwrSaveGrant = pwrSaveReq && !goBit;
  assign flashReady   = !wakeBusy;

endmodule

// File: rtl/flash_ctl_chk.sv
module flash_ctl_chk (
  input logic        clk,
  input logic        porRstN,
  input logic        regWrEn,
  input logic        wrGo,
  input logic [15:0] regRdData,
  input logic        cmdStart,
  input logic        pwrSaveGrant,
  input logic        flashReady
);

  // R4: the command pulse lasts one cycle
  assert_cmd_single_R4: assert property (@(posedge clk) disable iff (!porRstN)
    cmdStart |=> !cmdStart);

  // R2: a command is only sent while the start bit is set
  assert_cmd_while_busy_R2: assert property (@(posedge clk) disable iff (!porRstN)
    cmdStart |-> regRdData[15]);

  // R1: unused bits stay zero
  assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!porRstN)
    regRdData[11:4] == 8'h00);

  // R10: power save never granted during a job
  assert_no_grant_busy_R10: assert property (@(posedge clk) disable iff (!porRstN)
    pwrSaveGrant |-> !regRdData[15]);

  // R7: code and enable frozen while busy
  assert_fields_frozen_R7: assert property (@(posedge clk) disable iff (!porRstN)
    (regRdData[15] && $past(regRdData[15])) |-> $stable(regRdData[14]) && $stable(regRdData[3:0]));

  // R12: a start attempted during the wake window never launches
  assert_wake_blocks_R12: assert property (@(posedge clk) disable iff (!porRstN)
    (!flashReady && regWrEn && wrGo && !regRdData[15]) |=> !regRdData[15]);

endmodule

bind flash_ctl_unit flash_ctl_chk u_chk (
  .clk(clk), .porRstN(porRstN), .regWrEn(regWrEn), .wrGo(regWrData[15]),
  .regRdData(regRdData), .cmdStart(cmdStart), .pwrSaveGrant(pwrSaveGrant),
  .flashReady(flashReady)
);

// File: tb/test_flash_ctl_unit.sv
module test_flash_ctl_unit;

  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 16;
  localparam int WAKE_CYC    = 8;
  localparam int TIMEOUT_CYC = 64;
  localparam int FLASH_LAT   = 12;

  logic              clk = 1'b0;
  logic              porRstN = 1'b0;
  logic              sysRstN = 1'b1;
  logic              regWrEn = 1'b0;
  logic [15:0]       regWrData = '0;
  logic [15:0]       regRdData;
  logic [ADDR_W-1:0] addrIn = '0;
  logic              idleIn = 1'b0;
  logic              pwrSaveReq = 1'b0;
  logic              pwrSaveGrant;
  logic              flashReady;
  logic              cmdStart;
  logic [2:0]        cmdOp;
  logic [ADDR_W-1:0] cmdAddr;
  logic              cmdDone = 1'b0;

  int nCmp = 0;
  int nBad = 0;
  bit runDone = 1'b0;

  // flash responder
  int                nStarts = 0;
  logic [2:0]        seenOp = '0;
  logic [ADDR_W-1:0] lastAddr = '0;
  logic [ADDR_W-1:0] prevAddr = '0;
  int                pending = 0;
  bit                hang = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_ctl_unit #(
    .ADDR_W(ADDR_W), .WAKE_CYC(WAKE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) i_flash_ctl_unit (.*);

  always @(posedge clk) begin
    cmdDone <= 1'b0;
    if (cmdStart) begin
      nStarts  <= nStarts + 1;
      seenOp   <= cmdOp;
      prevAddr <= lastAddr;
      lastAddr <= cmdAddr;
      pending  <= FLASH_LAT;
    end else if (pending != 0) begin
      pending <= pending - 1;
      if (pending == 1 && !hang) cmdDone <= 1'b1;
    end
  end

  function automatic bit expLegal(input logic [3:0] c);
    return (c == 4'h0 || c == 4'h1 || c == 4'h2 || c == 4'h3 || c == 4'hA || c == 4'hD);
  endfunction

  function automatic logic [2:0] expKind(input logic [3:0] c);
    case (c)
      4'h1: return 3'd1;
      4'h2: return 3'd2;
      4'h3: return 3'd3;
      4'hA: return 3'd4;
      4'hD: return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [15:0] expReg(input bit go, input bit en, input bit err,
                                         input bit stby, input logic [3:0] c);
    return {go, en, err, stby, 8'h00, c};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [15:0] d);
    regWrEn   = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400 && regRdData[15]; i++) @(negedge clk);
  endtask

  // Start a job and check command stream and final register
  task automatic runOp(input logic [3:0] c, input logic [ADDR_W-1:0] a, input bit stby);
    int base;
    base   = nStarts;
    addrIn = a;
    regWrite(expReg(1'b1, 1'b1, 1'b0, stby, c));
    if (expLegal(c)) begin
      chk("R4 pulse after write", {31'd0, cmdStart}, 32'd1);
      waitIdle();
      chk("R6/R4 command count", nStarts - base, (c == 4'h1) ? 2 : 1);
      chk("R4 op kind", {29'd0, seenOp}, {29'd0, expKind(c)});
      if (c == 4'h1) begin
        chk("R6 first address", {16'd0, prevAddr}, {16'd0, a});
        chk("R6 second address", {16'd0, lastAddr}, {16'd0, a + 16'd1});
      end else begin
        chk("R4 address", {16'd0, lastAddr}, {16'd0, a});
      end
      chk("R2 final register", {16'd0, regRdData}, {16'd0, expReg(1'b0, 1'b1, 1'b0, stby, c)});
    end else begin
      chk("R5 rejected register", {16'd0, regRdData}, {16'd0, expReg(1'b0, 1'b1, 1'b1, stby, c)});
      repeat (3) @(negedge clk);
      chk("R5 no command", nStarts - base, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!runDone) begin
      nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [3:0] pool [8];
    seed = $urandom(32'd20240611);
    pool = '{4'h0, 4'h1, 4'h2, 4'h3, 4'hA, 4'hD, 4'hB, 4'h7};

    repeat (3) @(negedge clk);
    chk("R1 reset register", {16'd0, regRdData}, 32'd0);
    chk("R1 reset command", {31'd0, cmdStart}, 32'd0);
    porRstN = 1'b1;
    @(negedge clk);
    chk("R12 ready after reset", {31'd0, flashReady}, 32'd1);

    // R1/R13: junk in unused bits, fields load
    regWrite(16'h6FF2);
    chk("R1 unused bits dropped", {16'd0, regRdData}, 32'h0000_6002);
    regWrite(16'h0000);
    chk("R13 error cleared by write", {16'd0, regRdData}, 32'd0);

    // R3: start without enable
    begin
      int base;
      base = nStarts;
      regWrite(16'h8003);
      chk("R3 error on disabled start", {16'd0, regRdData}, 32'h0000_2003);
      repeat (3) @(negedge clk);
      chk("R3 no command", nStarts - base, 0);
    end

    // R4/R5/R6: every legal code and a few illegal ones
    runOp(4'h0, 16'h0100, 1'b0);
    runOp(4'h1, 16'h0FFF, 1'b0);
    runOp(4'h2, 16'h1234, 1'b1);
    runOp(4'h3, 16'h4000, 1'b0);
    runOp(4'hA, 16'hABCD, 1'b0);
    runOp(4'hD, 16'hFFFF, 1'b0);
    runOp(4'hC, 16'h0001, 1'b0);
    runOp(4'hF, 16'h0002, 1'b0);
    runOp(4'h5, 16'h0003, 1'b0);
    regWrite(16'h0000);

    // R7 and R10: write while busy, power save refused
    addrIn     = 16'h2222;
    pwrSaveReq = 1'b1;
    regWrite(16'hC002);
    chk("R10 grant while busy", {31'd0, pwrSaveGrant}, 32'd0);
    regWrite(16'hA00D);
    chk("R7 busy write ignored", {16'd0, regRdData}, 32'h0000_C002);
    waitIdle();
    chk("R10 grant when idle", {31'd0, pwrSaveGrant}, 32'd1);
    pwrSaveReq = 1'b0;
    chk("R2 done after busy write", {16'd0, regRdData}, 32'h0000_4002);

    // R8: abort
    regWrite(16'hC003);
    repeat (3) @(negedge clk);
    regWrite(16'h4003);
    chk("R8 abort register", {16'd0, regRdData}, 32'h0000_6003);
    repeat (30) @(negedge clk);
    regWrite(16'h0000);

    // R9: timeout
    hang = 1'b1;
    regWrite(16'hC002);
    repeat (TIMEOUT_CYC / 2) @(negedge clk);
    chk("R9 still busy mid-window", {31'd0, regRdData[15]}, 32'd1);
    repeat (TIMEOUT_CYC) @(negedge clk);
    chk("R9 timeout register", {16'd0, regRdData}, 32'h0000_6002);
    hang = 1'b0;
    repeat (20) @(negedge clk);

    // R11: system reset keeps most fields
    regWrite(16'h7003);
    sysRstN = 1'b0;
    repeat (2) @(negedge clk);
    sysRstN = 1'b1;
    @(negedge clk);
    chk("R11 after system reset", {16'd0, regRdData}, 32'h0000_6003);

    // R12: wake window exact length
    regWrite(16'h1000);
    idleIn = 1'b1;
    repeat (3) @(negedge clk);
    idleIn = 1'b0;
    @(negedge clk);
    chk("R12 window opens", {31'd0, flashReady}, 32'd0);
    repeat (WAKE_CYC - 1) @(negedge clk);
    chk("R12 window last cycle", {31'd0, flashReady}, 32'd0);
    @(negedge clk);
    chk("R12 window closes", {31'd0, flashReady}, 32'd1);

    // R12: start attempt inside the window
    begin
      int base;
      base   = nStarts;
      idleIn = 1'b1;
      repeat (3) @(negedge clk);
      idleIn = 1'b0;
      @(negedge clk);
      regWrite(16'hD001);
      chk("R12 start in window rejected", {16'd0, regRdData}, 32'h0000_7001);
      repeat (WAKE_CYC + 4) @(negedge clk);
      chk("R12 no command in window", nStarts - base, 0);
    end

    // R12: no window when standby bit is clear
    regWrite(16'h0000);
    idleIn = 1'b1;
    repeat (3) @(negedge clk);
    idleIn = 1'b0;
    @(negedge clk);
    chk("R12 no window without standby", {31'd0, flashReady}, 32'd1);

    // Random register traffic (R13, R3, R5, R4)
    for (int k = 0; k < 60; k++) begin
      logic [15:0] d;
      logic [3:0]  c;
      int          base;
      d      = 16'($urandom);
      c      = pool[$urandom % 8];
      d[3:0] = c;
      addrIn = 16'($urandom);
      base   = nStarts;
      regWrite(d);
      if (d[15] && d[14] && expLegal(c)) begin
        waitIdle();
        chk("R4 random job count", nStarts - base, (c == 4'h1) ? 2 : 1);
        chk("R2 random job end", {16'd0, regRdData},
            {16'd0, expReg(1'b0, 1'b1, 1'b0, d[12], c)});
      end else begin
        chk("R13 random load", {16'd0, regRdData},
            {16'd0, expReg(1'b0, d[14], d[15] | d[13], d[12], c)});
        @(negedge clk);
        chk("R5 random no command", nStarts - base, 0);
      end
    end

    runDone = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule